// File: doc/BRIEF.md
# Converter Serial Control and Readout Port

This block is the digital side of a serial converter's host port. A frame opens when the active-low chip select falls. During the frame, the port shifts a 16-bit control word in from the data input and shifts the last completed conversion result out on the data output. The sampling convention is SPI mode 0. The output is only driven while a frame is open; otherwise its enable is low and the pin floats. All pins are asynchronous to the system clock. Chip select, serial clock and data input are synchronized, and their edges are detected in the system clock domain, so the serial clock period must be at least four system clocks.

When chip select rises, the port checks the captured control word. A conversion starts only if the frame had at least 16 rising serial clock edges and the first control bit was 1. The first bit sits at bit 15 of the word. A frame whose first bit is 0 only reads. The converter core receives a one-cycle start pulse with the control word, and the active-low busy output is held low until the core returns a done pulse with its result. If chip select falls while a conversion is running, the port sends an abort pulse to the core and keeps the previous result. A done pulse that arrives while the port is idle is ignored.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, busy_no is 1, dout_oe_o is 0, start_o and abort_o are 0, and the first read returns 16'h0000.
- R2: dout_oe_o is 1 while a frame is open and returns to 0 within four system clocks after cs_ni rises.
- R3: The result is read as 16 bits, MSB first: bit 15 is the sign, bit 14 is the overrange bit, and bits 13..0 are data in two's complement. Bit 15 is on dout_o before the first rising SCLK edge, and each falling SCLK edge advances one bit.
- R4: din_i is sampled on rising SCLK edges. The first bit sampled lands in bit 15 of ctrl_word_o, and ctrl_word_o is valid while start_o is high.
- R5: On a chip select rise after a full frame whose bit 15 is 1, start_o pulses for exactly one cycle and busy_no goes low in the same cycle.
- R6: A full frame whose first control bit (bit 15) is 0 starts no conversion.
- R7: A frame with fewer than 16 rising SCLK edges starts no conversion, whatever its first bit.
- R8: done_i while busy returns busy_no to 1 on the next cycle and latches result_i for the next read.
- R9: A chip select fall while busy pulses abort_o for one cycle, returns busy_no to 1 and latches no result. The next read returns the last completed result.
- R10: done_i while idle has no effect on busy_no or on the result that is read.
- R11: SCLK edges while chip select is high do not shift either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous, idles low |
| din_i | input | 1 | Serial control data in |
| dout_o | output | 1 | Serial result data out |
| dout_oe_o | output | 1 | Output enable for the dout pad driver |
| busy_no | output | 1 | Low while a conversion runs |
| start_o | output | 1 | One-cycle start pulse to the converter core |
| abort_o | output | 1 | One-cycle abort pulse to the converter core |
| ctrl_word_o | output | 16 | Control word captured for the started conversion |
| done_i | input | 1 | Conversion complete pulse from the core |
| result_i | input | 16 | Result word from the core, valid with done_i |

## Verification
A wrong bit counter or shift register shows up in the next frame. Either the word read on dout_o is rotated or corrupted, or start_o fires on a short frame or a read-only frame, visible three to four clocks after chip select rises. A wrong sequencer state shows on busy_no within one cycle of done_i or of a chip select fall. A wrongly latched result shows on the following read. The random part of the bench varies result and control words with a fixed seed, so the sign and overrange bit positions and every data bit are covered.

// File: rtl/conv_port_pkg.sv
package conv_port_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned SYNC_STAGES = 2;
  typedef enum logic {SEQ_IDLE, SEQ_CONV} seq_state_e;
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/cp_edge.sv
module cp_edge #(
  parameter int unsigned W        = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/cp_frame_shifter.sv
module cp_frame_shifter #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_open_i,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              din_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic              dout_o,
  output logic              oe_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              full_o
);
  logic [WORD_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              oe_q;
  logic              shift_ok;

  assign shift_ok = frame_open_i && !frame_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= frame_open_i;
      if (frame_start_i) begin
        tx_q  <= load_word_i;
        rx_q  <= '0;
        cnt_q <= '0;
      end else if (shift_ok) begin
        if (sclk_fall_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        if (sclk_rise_i) begin
          rx_q <= {rx_q[WORD_W-2:0], din_i};
          if (cnt_q != CNT_W'(WORD_W)) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign dout_o    = oe_q & tx_q[WORD_W-1];
  assign oe_o      = oe_q;
  assign rx_word_o = rx_q;
  assign full_o    = (cnt_q == CNT_W'(WORD_W));

  // R2: enable drops once chip select is seen high
  p_oe_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> !oe_o);
  // R7: counter never passes the frame length
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W));
  // R11: no shifting outside a frame
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_open_i && !$past(frame_open_i)) |=> $stable(rx_q));
endmodule

// File: rtl/cp_conv_seq.sv
module cp_conv_seq
  import conv_port_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] result_i,
  output logic              start_o,
  output logic              abort_o,
  output logic              busy_no,
  output logic [WORD_W-1:0] ctrl_word_o,
  output logic [WORD_W-1:0] read_word_o
);
  seq_state_e        state_q, state_d;
  logic [WORD_W-1:0] result_q, ctrl_q;
  logic              start_q, abort_q;
  logic              launch, accept, kill;

  assign accept = done_i && (state_q == SEQ_CONV);
  assign kill   = frame_start_i && (state_q == SEQ_CONV) && !done_i;
  // first control bit gates the start
  assign launch = frame_end_i && full_i && rx_word_i[WORD_W-1] && (state_q == SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    if (accept || kill) state_d = SEQ_IDLE;
    else if (launch)    state_d = SEQ_CONV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      result_q <= '0;
      ctrl_q   <= '0;
      start_q  <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= launch;
      abort_q <= kill;
      if (accept) result_q <= result_i;
      if (launch) ctrl_q   <= rx_word_i;
    end
  end

  assign start_o     = start_q;
  assign abort_o     = abort_q;
  assign busy_no     = (state_q == SEQ_IDLE);
  assign ctrl_word_o = ctrl_q;
  assign read_word_o = accept ? result_i : result_q;

  // R5: start is a single pulse and coincides with busy low
  p_start_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_start_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_no);
  // R6: a started word always has its first bit set
  p_start_noop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ctrl_word_o[WORD_W-1]);
  // R7: a start follows a full frame
  p_start_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(full_i));
  // R8: completion frees the port
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !busy_no) |=> busy_no);
  // R9: abort frees the port and keeps the result
  p_abort_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (busy_no && $past(!busy_no)));
  p_abort_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $stable(result_q));
  // R10: idle done is ignored
  p_idle_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_no && !launch) |=> (busy_no && $stable(result_q)));
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import conv_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              busy_no,
  output logic              start_o,
  output logic              abort_o,
  output logic [WORD_W-1:0] ctrl_word_o,
  input  logic              done_i,
  input  logic [WORD_W-1:0] result_i
);
  logic [2:0]        pin_lvl;
  logic [1:0]        pin_rise, pin_fall;
  logic [WORD_W-1:0] rx_word, read_word;
  logic              full;

  // bit 2 din, bit 1 sclk, bit 0 cs_n
  cp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({din_i, sclk_i, cs_ni}),
    .level_o (pin_lvl)
  );

  cp_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (pin_lvl[1:0]),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  cp_frame_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_open_i  (!pin_lvl[0]),
    .frame_start_i (pin_fall[0]),
    .frame_end_i   (pin_rise[0]),
    .sclk_rise_i   (pin_rise[1]),
    .sclk_fall_i   (pin_fall[1]),
    .din_i         (pin_lvl[2]),
    .load_word_i   (read_word),
    .dout_o        (dout_o),
    .oe_o          (dout_oe_o),
    .rx_word_o     (rx_word),
    .full_o        (full)
  );

  cp_conv_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (pin_fall[0]),
    .frame_end_i   (pin_rise[0]),
    .full_i        (full),
    .rx_word_i     (rx_word),
    .done_i        (done_i),
    .result_i      (result_i),
    .start_o       (start_o),
    .abort_o       (abort_o),
    .busy_no       (busy_no),
    .ctrl_word_o   (ctrl_word_o),
    .read_word_o   (read_word)
  );

  // R1: nothing is driven toward the core out of reset
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (busy_no && !start_o && !abort_o));
endmodule

// File: tb/conv_serial_port_bench.sv
module conv_serial_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0, done = 1'b0;
  logic [15:0] result = '0;
  logic        dout, dout_oe, busy_n, start, abort;
  logic [15:0] ctrl_word;

  int n_chk = 0, n_bad = 0;
  int n_start = 0, n_abort = 0;
  logic [15:0] seen_ctrl = '0;
  logic [15:0] last_res = '0;

  always #4 clk = ~clk;

  conv_serial_port u_conv_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .busy_no(busy_n), .start_o(start),
    .abort_o(abort), .ctrl_word_o(ctrl_word), .done_i(done), .result_i(result)
  );

  always @(posedge clk) begin
    if (start) begin n_start++; seen_ctrl = ctrl_word; end
    if (abort) n_abort++;
  end

  function automatic logic [15:0] pack_res(logic sgn, logic ovr, logic [13:0] mag);
    return {sgn, ovr, mag};
  endfunction

  task automatic ck(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] ctrl, input int nbits, output logic [15:0] got);
    bit oe_ok = 1'b1;
    got = '0;
    cs_n = 1'b0;
    wclk(4);
    for (int i = 0; i < nbits; i++) begin
      din = ctrl[15-i];
      wclk(4);
      if (!dout_oe) oe_ok = 1'b0;
      if (i < 16) got[15-i] = dout;
      sclk = 1'b1;
      wclk(4);
      sclk = 1'b0;
    end
    wclk(4);
    cs_n = 1'b1;
    wclk(5);
    ck(oe_ok && !dout_oe, "R2 oe", {30'd0, oe_ok, dout_oe}, 32'd2);
  endtask

  task automatic finish_conv(input logic [15:0] r);
    result = r;
    done = 1'b1;
    wclk(1);
    done = 1'b0;
    wclk(1);
  endtask

  initial begin
    logic [15:0] got, r, c;
    int s0, a0;
    void'($urandom(32'h5eed_1234));
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    ck(busy_n && !dout_oe && !start && !abort, "R1 reset outputs",
       {busy_n, dout_oe, start, abort}, 32'h8);

    // R11: SCLK toggles with chip select high
    for (int k = 0; k < 5; k++) begin sclk = 1'b1; wclk(4); sclk = 1'b0; wclk(4); end
    frame(16'h5a5a, 16, got);
    ck(got == 16'h0000, "R1/R11 first read", got, 16'h0000);
    ck(n_start == 0, "R6 read-only frame", n_start, 0);

    // R4 R5 start
    frame(16'ha5c3, 16, got);
    ck(n_start == 1, "R5 start count", n_start, 1);
    ck(seen_ctrl == 16'ha5c3, "R4 ctrl word", seen_ctrl, 16'ha5c3);
    ck(!busy_n, "R5 busy low", busy_n, 0);

    // R8 completion, R3 order with sign and overrange
    r = pack_res(1'b1, 1'b0, 14'h0001);
    finish_conv(r);
    last_res = r;
    ck(busy_n, "R8 busy released", busy_n, 1);
    frame(16'h1234, 16, got);
    ck(got == last_res, "R3/R8 readback", got, last_res);
    ck(n_start == 1, "R6 no start", n_start, 1);

    // R9 abort
    frame(16'hffff, 16, got);
    ck(!busy_n, "R5 busy again", busy_n, 0);
    a0 = n_abort;
    frame(16'h0000, 16, got);
    ck(n_abort == a0 + 1, "R9 abort pulse", n_abort, a0 + 1);
    ck(busy_n, "R9 busy released", busy_n, 1);
    ck(got == last_res, "R9 read during abort", got, last_res);

    // R10 idle done
    finish_conv(16'h7777);
    ck(busy_n, "R10 busy stays", busy_n, 1);
    frame(16'h0000, 16, got);
    ck(got == last_res, "R10 result kept", got, last_res);

    // R7 short frames
    s0 = n_start;
    frame(16'h8000, 10, got);
    frame(16'hffff, 15, got);
    ck(n_start == s0, "R7 short frame", n_start, s0);
    ck(busy_n, "R7 still idle", busy_n, 1);

    // random mix
    for (int k = 0; k < 16; k++) begin
      c = 16'($urandom) | 16'h8000;
      s0 = n_start;
      frame(c, 16, got);
      ck(got == last_res, "R3 random read", got, last_res);
      ck(n_start == s0 + 1 && seen_ctrl == c, "R4/R5 random start", seen_ctrl, c);
      r = pack_res(1'($urandom), 1'($urandom), 14'($urandom));
      wclk(int'($urandom % 20));
      finish_conv(r);
      last_res = r;
      ck(busy_n, "R8 random release", busy_n, 1);
    end
    frame(16'h0000, 16, got);
    ck(got == last_res, "R3 final read", got, last_res);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule